// File: doc/BRIEF.md
# Packet Controller Interrupt Status Unit

This block keeps the interrupt state of a packet-buffer network controller. It holds an 8-bit status byte and an 8-bit enable mask, and drives one level-sensitive interrupt line. Single-cycle event pulses from the receive and allocation logic set status bits. Two bits follow live queue flags: the transmit queue being empty and the transmit-completion queue holding entries. Software clears bits by writing an acknowledge byte. Acknowledging the transmit-done bit also sends a pop strobe to the completion queue.

The queues, the packet memory and the register decoder sit outside. The decoder turns bus writes into the acknowledge and mask write strobes. The queue logic supplies the two level flags and consumes the pop strobe. It also issues the hardware clears for the receive and allocation bits, which software cannot clear.

Top module: `pkt_irq_status`

## Requirements
- R1: Status bit layout: bit0 receive-queued (set by `ev_rcv`), bit1 transmit-done, bit2 transmit-queue-empty, bit3 allocation-done (set by `ev_alloc`), bit4 receive overrun (set by `ev_overrun`), bit6 early receive (set by `ev_early_rx`). Bits 5 and 7 have no source and read 0. An event pulse shows in `status` after the next rising edge.
- R2: While `tx_q_empty` is high, bit2 is set at every edge. Bit2 stays set after the flag drops, until it is acknowledged.
- R3: While `txdone_nonempty` is high and no pop is issued in that cycle, bit1 is set at the next edge.
- R4: An acknowledge write clears exactly the written bits that fall inside 0xD6 (bits 1, 2, 4, 6, 7). Bits 0 and 3 are not changed by an acknowledge.
- R5: `txdone_pop` is high in the same cycle as an acknowledge write with bit1 set, but only while `txdone_nonempty` is high. It is low otherwise.
- R6: `irq` is a register. After each edge it equals the OR of (`status` AND `mask`) as they stood before that edge, so it lags `status` and `mask` by one edge.
- R7: After reset, `status` is 0x04, `mask` is 0x00 and `irq` is 0.
- R8: When a set source and a clear (acknowledge or hardware clear) hit the same bit in the same cycle, the bit ends up set.
- R9: `rcv_clr` clears bit0 and `alloc_clr` clears bit3 at the next edge.
- R10: A mask write replaces the whole mask byte at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rcv | input | 1 | Pulse: a received packet was queued |
| ev_alloc | input | 1 | Pulse: a transmit allocation completed |
| ev_overrun | input | 1 | Pulse: a receive overrun occurred |
| ev_early_rx | input | 1 | Pulse: the early-receive threshold was reached |
| rcv_clr | input | 1 | Hardware clear of the receive-queued bit |
| alloc_clr | input | 1 | Hardware clear of the allocation-done bit |
| tx_q_empty | input | 1 | Level: transmit queue length is zero |
| txdone_nonempty | input | 1 | Level: transmit-completion queue holds entries |
| ack_we | input | 1 | Acknowledge register write strobe |
| ack_data | input | 8 | Acknowledge write data |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | Mask write data |
| irq | output | 1 | Registered interrupt line |
| status | output | 8 | Current status byte |
| mask | output | 8 | Current mask byte |
| txdone_pop | output | 1 | Strobe that removes one completion-queue entry |

## Verification
A corrupted status bit shows on `status` right after the offending edge. It reaches `irq` one edge later, but only if that bit's mask bit is set, so the tests enable the mask per bit before watching the line. A wrong acknowledge mask shows up as a bit that survives, or as bit0 or bit3 vanishing. A wrong pop gate shows as a strobe in the same cycle against an empty queue, or as transmit-done failing to come back one edge after an acknowledge while entries remain.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;
   localparam int unsigned STAT_BITS = 8;
   localparam int unsigned B_RCV     = 0;
   localparam int unsigned B_TX      = 1;
   localparam int unsigned B_TXE     = 2;
   localparam int unsigned B_ALLOC   = 3;
   localparam int unsigned B_OVR     = 4;
   localparam int unsigned B_ERX     = 6;
   localparam logic [STAT_BITS-1:0] ACK_CLEARABLE = 8'hD6;
   localparam logic [STAT_BITS-1:0] NO_SOURCE     = 8'hA0;
   localparam logic [STAT_BITS-1:0] STAT_RESET    = 8'h04;
endpackage

// File: rtl/irq_stat_bit.sv
module irq_stat_bit #(
   parameter bit RST_VAL = 1'b0,
   parameter bit TIED    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   generate
      if (TIED) begin : g_tied
         assign q_o = 1'b0;
      end else begin : g_live
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)     q <= RST_VAL;
            else if (set_i) q <= 1'b1;
            else if (clr_i) q <= 1'b0;
         end
         assign q_o = q;
      end
   endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end
endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(stat_i & en_i);
   end
endmodule

// File: rtl/pkt_irq_status.sv
module pkt_irq_status
   import pkt_irq_pkg::*;
#(
   parameter int unsigned           STAT_W   = STAT_BITS,
   parameter logic [STAT_BITS-1:0]  ACK_MASK = ACK_CLEARABLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_rcv,
   input  logic              ev_alloc,
   input  logic              ev_overrun,
   input  logic              ev_early_rx,
   input  logic              rcv_clr,
   input  logic              alloc_clr,
   input  logic              tx_q_empty,
   input  logic              txdone_nonempty,
   input  logic              ack_we,
   input  logic [STAT_W-1:0] ack_data,
   input  logic              mask_we,
   input  logic [STAT_W-1:0] mask_data,
   output logic              irq,
   output logic [STAT_W-1:0] status,
   output logic [STAT_W-1:0] mask,
   output logic              txdone_pop
);
   localparam int unsigned W = STAT_W;

   generate
      if (W != STAT_BITS) begin : g_bad_width
         $error("pkt_irq_status: STAT_W must equal the fixed status layout width");
      end
   endgenerate

   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;

   assign txdone_pop = ack_we & ack_data[B_TX] & txdone_nonempty;

   always_comb begin
      set_v          = '0;
      set_v[B_RCV]   = ev_rcv;
      set_v[B_ALLOC] = ev_alloc;
      set_v[B_OVR]   = ev_overrun;
      set_v[B_ERX]   = ev_early_rx;
      set_v[B_TXE]   = tx_q_empty;
      set_v[B_TX]    = txdone_nonempty & ~txdone_pop;
   end

   always_comb begin
      clr_v          = ack_we ? (ack_data & ACK_MASK) : '0;
      clr_v[B_RCV]   = clr_v[B_RCV] | rcv_clr;
      clr_v[B_ALLOC] = clr_v[B_ALLOC] | alloc_clr;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      irq_stat_bit #(
         .RST_VAL (STAT_RESET[i]),
         .TIED    (NO_SOURCE[i])
      ) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_v[i]),
         .clr_i (clr_v[i]),
         .q_o   (status[i])
      );
   end

   irq_mask_reg #(.W(W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (mask_we),
      .d_i   (mask_data),
      .q_o   (mask)
   );

   irq_line_reg #(.W(W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (status),
      .en_i   (mask),
      .irq_o  (irq)
   );

   // R2: live empty flag forces the bit at the next edge
   p_txempty_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_q_empty |=> status[B_TXE]);
   // R3: completion entries re-assert transmit-done unless popped
   p_txdone_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (txdone_nonempty && !txdone_pop) |=> status[B_TX]);
   // R4: acknowledge cannot remove receive-queued
   p_rcv_ack_immune_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_RCV] && !rcv_clr) |=> status[B_RCV]);
   // R4: acknowledge cannot remove allocation-done
   p_alloc_ack_immune_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status[B_ALLOC] && !alloc_clr) |=> status[B_ALLOC]);
   // R4: overrun acknowledged without a new event is gone
   p_ovr_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_data[B_OVR] && !ev_overrun) |=> !status[B_OVR]);
   // R5: never pop an empty completion queue
   p_no_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      txdone_pop |-> txdone_nonempty);
   // R6: line follows masked status one edge later
   p_irq_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|(status & mask)) |=> irq);
   p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status & mask)) |=> !irq);
   // R8: receive event beats a same-cycle clear
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rcv |=> status[B_RCV]);
   // R10: mask write lands whole
   p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we |=> (mask == $past(mask_data)));
endmodule

// File: tb/pkt_irq_status_tb.sv
module pkt_irq_status_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_rcv = 0, ev_alloc = 0, ev_overrun = 0, ev_early_rx = 0;
   logic       rcv_clr = 0, alloc_clr = 0;
   logic       tx_q_empty = 1, txdone_nonempty = 0;
   logic       ack_we = 0, mask_we = 0;
   logic [7:0] ack_data = 0, mask_data = 0;
   logic       irq, txdone_pop;
   logic [7:0] status, mask;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pkt_irq_status u_dut (
      .clk(clk), .rst_n(rst_n),
      .ev_rcv(ev_rcv), .ev_alloc(ev_alloc), .ev_overrun(ev_overrun),
      .ev_early_rx(ev_early_rx), .rcv_clr(rcv_clr), .alloc_clr(alloc_clr),
      .tx_q_empty(tx_q_empty), .txdone_nonempty(txdone_nonempty),
      .ack_we(ack_we), .ack_data(ack_data),
      .mask_we(mask_we), .mask_data(mask_data),
      .irq(irq), .status(status), .mask(mask), .txdone_pop(txdone_pop)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic ack(input logic [7:0] v);
      ack_we = 1; ack_data = v;
      step();
      ack_we = 0; ack_data = 0;
   endtask

   task automatic t_reset();
      chk("R7 status", status, 8'h04);
      chk("R7 mask", mask, 8'h00);
      chk("R7 irq", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_events_and_ack();
      tx_q_empty = 0;
      ev_rcv = 1; ev_alloc = 1; ev_overrun = 1; ev_early_rx = 1;
      step();
      ev_rcv = 0; ev_alloc = 0; ev_overrun = 0; ev_early_rx = 0;
      chk("R1 events", status, 8'h5D);
      ack(8'hFF);
      chk("R4 ack keeps bits 0,3", status, 8'h09);
      rcv_clr = 1; step(); rcv_clr = 0;
      chk("R9 rcv_clr", status, 8'h08);
      alloc_clr = 1; step(); alloc_clr = 0;
      chk("R9 alloc_clr", status, 8'h00);
   endtask

   task automatic t_txempty();
      tx_q_empty = 1; step();
      chk("R2 set", status, 8'h04);
      tx_q_empty = 0; step();
      chk("R2 sticky", status, 8'h04);
      ack(8'h04);
      chk("R2 ack clears", status, 8'h00);
   endtask

   task automatic t_txdone();
      txdone_nonempty = 1; step();
      chk("R3 set", status, 8'h02);
      ack_we = 1; ack_data = 8'h02; #1;
      chk("R5 pop", {7'b0, txdone_pop}, 8'h01);
      step(); ack_we = 0; ack_data = 0;
      chk("R3 cleared in pop cycle", status, 8'h00);
      step();
      chk("R3 reasserts", status, 8'h02);
      ack_we = 1; ack_data = 8'h01; #1;
      chk("R5 no pop bit1 clear", {7'b0, txdone_pop}, 8'h00);
      step(); ack_we = 0; ack_data = 0;
      ack(8'h02);
      txdone_nonempty = 0; step();
      chk("R3 stays clear", status, 8'h00);
      ack_we = 1; ack_data = 8'h02; #1;
      chk("R5 no pop empty", {7'b0, txdone_pop}, 8'h00);
      step(); ack_we = 0; ack_data = 0;
   endtask

   task automatic t_irq_mask();
      mask_we = 1; mask_data = 8'h40; step(); mask_we = 0;
      chk("R10 mask", mask, 8'h40);
      chk("R6 idle", {7'b0, irq}, 8'h00);
      ev_early_rx = 1; step(); ev_early_rx = 0;
      chk("R1 early rx", status, 8'h40);
      chk("R6 lag", {7'b0, irq}, 8'h00);
      step();
      chk("R6 high", {7'b0, irq}, 8'h01);
      mask_we = 1; mask_data = 8'h00; step(); mask_we = 0;
      chk("R6 still high", {7'b0, irq}, 8'h01);
      step();
      chk("R6 masked off", {7'b0, irq}, 8'h00);
      ack(8'h40);
      chk("R4 early rx ack", status, 8'h00);
   endtask

   task automatic t_set_wins();
      ev_overrun = 1; ev_rcv = 1; ev_alloc = 1;
      rcv_clr = 1; alloc_clr = 1; ack_we = 1; ack_data = 8'h10;
      step();
      ev_overrun = 0; ev_rcv = 0; ev_alloc = 0;
      rcv_clr = 0; alloc_clr = 0; ack_we = 0; ack_data = 0;
      chk("R8 set wins", status, 8'h19);
      tx_q_empty = 1; ack_we = 1; ack_data = 8'h04; step();
      ack_we = 0; ack_data = 0;
      chk("R8 txempty wins", status[2:2], 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();
      t_reset();
      t_events_and_ack();
      t_txempty();
      t_txdone();
      t_irq_mask();
      t_set_wins();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule